// File: doc/BRIEF.md
# Serial Fuse Word Burner

This block burns a single 32-bit word into a one-time-programmable fuse array, one bit position per step. On a start pulse it latches the target word address, the data and a packed timing word. It then strobes a read of the addressed fuse word and clears from the data every bit that is already blown. The remaining word goes into a shift register that moves right with zero fill. Each position whose low bit is 1 gets a program strobe, framed by relax phases. A position whose low bit is 0 costs one cycle and gets no strobe. After the last position, a settling gap keeps the block busy before the next operation can start.

A separate reload pulse walks every fuse word in ascending index order. For each word it runs a relax phase and a read strobe, then gives a one-cycle shadow update that carries the word index and its contents. All phase lengths are counted in clock cycles and come from the timing word. The settling gap is a parameter. The fuse array is modelled inside the block as plain registers that clear on reset.

Top module: `fuse_burn_seq`

## Requirements
- R1: After reset, busy_o, fuse_rd_strobe_o, fuse_pg_strobe_o and shad_we_o are all 0.
- R2: A start_i pulse while idle raises busy_o in the next cycle. The block then gives exactly one read strobe on the addressed word before any program strobe of that operation.
- R3: Program strobes occur only for bits that are 1 in the data and still 0 in the fuse word. The number of strobes equals popcount(data & ~fuse), and a word of all zeros gives no strobe.
- R4: The word is burned serially, least significant bit first. During each strobe, fuse_bit_o holds the bit position and fuse_addr_o holds the latched address, and positions rise strictly within one operation.
- R5: The timing word is laid out as program strobe length in [11:0], relax count in [15:12] and read strobe length in [21:16]. Each program strobe lasts max(P,1) cycles and each read strobe lasts max(Rd,1) cycles.
- R6: Every non-strobe phase (before the read, before a program strobe and after a program strobe) lasts R+1 cycles. A position that needs no strobe costs 1 cycle.
- R7: After the last bit position, busy_o stays high for SETTLE_CYC more cycles. A program operation is therefore busy for (R+1)+max(Rd,1)+32+k*(2(R+1)+max(P,1))+SETTLE_CYC cycles, where k is the strobe count.
- R8: A fuse bit becomes 1 when its program strobe completes, and bits are never cleared. A later reload shows the OR of all burned data.
- R9: A reload_i pulse while idle reads every word in ascending index order. Each word takes R+1 relax cycles and max(Rd,1) read strobe cycles, then one cycle with shad_we_o=1, shad_addr_o equal to the index and shad_data_o equal to the word. The block is busy for N_WORDS*(R+max(Rd,1)+2) cycles.
- R10: start_i and reload_i are ignored while busy_o is 1. If both arrive in the same idle cycle, the program operation runs and no reload happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Program request pulse |
| reload_i | input | 1 | Shadow reload request pulse |
| addr_i | input | ADDR_W | Fuse word address to program |
| data_i | input | WORD_W | Word to burn (1 = blow bit) |
| timing_i | input | 22 | Packed timing: program [11:0], relax [15:12], read [21:16] |
| busy_o | output | 1 | Operation in progress, including settling gap |
| fuse_rd_strobe_o | output | 1 | Fuse read strobe |
| fuse_pg_strobe_o | output | 1 | Fuse program strobe |
| fuse_addr_o | output | ADDR_W | Fuse word being accessed |
| fuse_bit_o | output | BIT_W | Bit position being programmed |
| shad_we_o | output | 1 | Shadow word update strobe |
| shad_addr_o | output | ADDR_W | Shadow word index |
| shad_data_o | output | WORD_W | Shadow word contents |

## Verification
The bench builds the block with N_WORDS=4 and SETTLE_CYC=5. With these values a full reload takes only a few dozen cycles, so every shadow word can be compared against a model of the fuse array that the bench keeps itself. The short settling gap lets the exact busy length of each operation be checked for zero, minimum and larger timing fields. Re-programming the same word checks that blown bits are masked, and a request made during busy, or two requests in the same cycle, checks that the block ignores them.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

    localparam int PG_W  = 12;
    localparam int RLX_W = 4;
    localparam int RD_W  = 6;
    localparam int TIM_W = PG_W + RLX_W + RD_W;

    typedef struct packed {
        logic [RD_W-1:0]  rd_len;
        logic [RLX_W-1:0] relax;
        logic [PG_W-1:0]  pg_len;
    } fuse_timing_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_RELAX,
        ST_RD_STROBE,
        ST_BIT_EVAL,
        ST_PG_PRE,
        ST_PG_STROBE,
        ST_PG_POST,
        ST_SETTLE,
        ST_RL_RELAX,
        ST_RL_STROBE,
        ST_RL_WRITE
    } seq_state_e;

    // A strobe field of zero still yields a one-cycle strobe.
    function automatic int unsigned strobe_cycles(input int unsigned field);
        return (field == 0) ? 1 : field;
    endfunction

    // Relax count is added to a one-cycle base phase.
    function automatic int unsigned relax_cycles(input int unsigned field);
        return field + 1;
    endfunction

endpackage

// File: rtl/fuse_phase_timer.sv
module fuse_phase_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len - CNT_W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign done = (cnt == '0);

    // R5/R6: every phase loaded must be at least one cycle long
    a_r5_len_nonzero: assert property (@(posedge clk) disable iff (rst)
        load |-> (len != '0));

endmodule

// File: rtl/fuse_cell_array.sv
module fuse_cell_array #(
    parameter  int N_WORDS = 16,
    parameter  int WORD_W  = 32,
    localparam int ADDR_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int BIT_W   = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word,
    input  logic              blow,
    input  logic [ADDR_W-1:0] blow_addr,
    input  logic [BIT_W-1:0]  blow_bit
);
    logic [WORD_W-1:0] cells [N_WORDS];

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[w] <= '0;
            end else if (blow && (blow_addr == ADDR_W'(w))) begin
                cells[w][blow_bit] <= 1'b1;
            end
        end
    end

    assign rd_word = cells[rd_addr];

    // R3: a bit is never strobed once it is already blown
    a_r3_no_reblow: assert property (@(posedge clk) disable iff (rst)
        blow |-> !cells[blow_addr][blow_bit]);

    // R8: a blown bit is set in the cycle after the strobe completes
    a_r8_bit_set: assert property (@(posedge clk) disable iff (rst)
        blow |=> cells[$past(blow_addr)][$past(blow_bit)]);

endmodule

// File: rtl/fuse_bit_shifter.sv
module fuse_bit_shifter #(
    parameter  int WORD_W = 32,
    localparam int BIT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              latch,
    input  logic [WORD_W-1:0] data_i,
    input  logic              capture,
    input  logic [WORD_W-1:0] fuse_word,
    input  logic              advance,
    output logic              cur_bit,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              last_bit
);
    logic [WORD_W-1:0] data_q;
    logic [WORD_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            sh      <= '0;
            bit_idx <= '0;
        end else begin
            if (latch) begin
                data_q <= data_i;
            end
            if (capture) begin
                sh      <= data_q & ~fuse_word;
                bit_idx <= '0;
            end else if (advance) begin
                sh      <= sh >> 1;
                bit_idx <= bit_idx + BIT_W'(1);
            end
        end
    end

    assign cur_bit  = sh[0];
    assign last_bit = (bit_idx == BIT_W'(WORD_W - 1));

    // R3: the captured word has no overlap with already blown bits
    a_r3_masked: assert property (@(posedge clk) disable iff (rst)
        capture |=> ((sh & $past(fuse_word)) == '0));

    // R4: shifting fills from the top with zeros
    a_r4_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (advance && !capture) |=> (sh[WORD_W-1] == 1'b0));

endmodule

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl
    import fuse_seq_pkg::*;
#(
    parameter  int N_WORDS    = 16,
    parameter  int SETTLE_CYC = 200,
    parameter  int CNT_W      = 16,
    localparam int ADDR_W     = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              reload_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [TIM_W-1:0]  timing_i,
    input  logic              tmr_done,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_len,
    input  logic              cur_bit,
    input  logic              last_bit,
    output logic              sh_latch,
    output logic              sh_capture,
    output logic              sh_advance,
    output logic              blow,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              busy,
    output logic              rd_strobe,
    output logic              pg_strobe,
    output logic              shad_we
);
    seq_state_e        state, nxt;
    fuse_timing_t      tin, tm_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] widx;
    logic              take_pg, take_rl, widx_inc;
    logic [CNT_W-1:0]  rlx_in, rlx_n, rd_n, pg_n, settle_n;
    logic              last_word;

    assign tin       = timing_i;
    assign rlx_in    = CNT_W'(relax_cycles(32'(tin.relax)));
    assign rlx_n     = CNT_W'(relax_cycles(32'(tm_q.relax)));
    assign rd_n      = CNT_W'(strobe_cycles(32'(tm_q.rd_len)));
    assign pg_n      = CNT_W'(strobe_cycles(32'(tm_q.pg_len)));
    assign settle_n  = CNT_W'(SETTLE_CYC);
    assign last_word = (widx == ADDR_W'(N_WORDS - 1));

    always_comb begin
        nxt        = state;
        tmr_load   = 1'b0;
        tmr_len    = rlx_n;
        sh_capture = 1'b0;
        sh_advance = 1'b0;
        blow       = 1'b0;
        take_pg    = 1'b0;
        take_rl    = 1'b0;
        widx_inc   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_i) begin
                    take_pg  = 1'b1;
                    nxt      = ST_RD_RELAX;
                    tmr_load = 1'b1;
                    tmr_len  = rlx_in;
                end else if (reload_i) begin
                    take_rl  = 1'b1;
                    nxt      = ST_RL_RELAX;
                    tmr_load = 1'b1;
                    tmr_len  = rlx_in;
                end
            end
            ST_RD_RELAX: if (tmr_done) begin
                nxt      = ST_RD_STROBE;
                tmr_load = 1'b1;
                tmr_len  = rd_n;
            end
            ST_RD_STROBE: if (tmr_done) begin
                sh_capture = 1'b1;
                nxt        = ST_BIT_EVAL;
            end
            ST_BIT_EVAL: begin
                if (cur_bit) begin
                    nxt      = ST_PG_PRE;
                    tmr_load = 1'b1;
                    tmr_len  = rlx_n;
                end else begin
                    sh_advance = 1'b1;
                    if (last_bit) begin
                        nxt      = ST_SETTLE;
                        tmr_load = 1'b1;
                        tmr_len  = settle_n;
                    end
                end
            end
            ST_PG_PRE: if (tmr_done) begin
                nxt      = ST_PG_STROBE;
                tmr_load = 1'b1;
                tmr_len  = pg_n;
            end
            ST_PG_STROBE: if (tmr_done) begin
                blow     = 1'b1;
                nxt      = ST_PG_POST;
                tmr_load = 1'b1;
                tmr_len  = rlx_n;
            end
            ST_PG_POST: if (tmr_done) begin
                sh_advance = 1'b1;
                if (last_bit) begin
                    nxt      = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_len  = settle_n;
                end else begin
                    nxt = ST_BIT_EVAL;
                end
            end
            ST_SETTLE: if (tmr_done) begin
                nxt = ST_IDLE;
            end
            ST_RL_RELAX: if (tmr_done) begin
                nxt      = ST_RL_STROBE;
                tmr_load = 1'b1;
                tmr_len  = rd_n;
            end
            ST_RL_STROBE: if (tmr_done) begin
                nxt = ST_RL_WRITE;
            end
            ST_RL_WRITE: begin
                if (last_word) begin
                    nxt = ST_IDLE;
                end else begin
                    widx_inc = 1'b1;
                    nxt      = ST_RL_RELAX;
                    tmr_load = 1'b1;
                    tmr_len  = rlx_n;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            tm_q   <= '0;
            widx   <= '0;
        end else begin
            state <= nxt;
            if (take_pg) begin
                addr_q <= addr_i;
                tm_q   <= tin;
            end
            if (take_rl) begin
                tm_q <= tin;
                widx <= '0;
            end else if (widx_inc) begin
                widx <= widx + ADDR_W'(1);
            end
        end
    end

    assign sh_latch  = take_pg;
    assign arr_addr  = (state == ST_RL_RELAX || state == ST_RL_STROBE ||
                        state == ST_RL_WRITE) ? widx : addr_q;
    assign busy      = (state != ST_IDLE);
    assign rd_strobe = (state == ST_RD_STROBE) || (state == ST_RL_STROBE);
    assign pg_strobe = (state == ST_PG_STROBE);
    assign shad_we   = (state == ST_RL_WRITE);

    // R10: requests made while busy leave the latched address alone
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && start_i) |=> $stable(addr_q));

    // R3/R4: a program strobe only happens on a bit the shifter reports as 1
    a_r4_strobe_has_bit: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PG_STROBE) |-> cur_bit);

    // R9: shadow update of the last word ends the reload
    a_r9_reload_ends: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RL_WRITE && last_word) |=> (state == ST_IDLE));

endmodule

// File: rtl/fuse_burn_seq.sv
module fuse_burn_seq
    import fuse_seq_pkg::*;
#(
    parameter  int N_WORDS    = 16,
    parameter  int WORD_W     = 32,
    parameter  int SETTLE_CYC = 200,
    parameter  int CNT_W      = 16,
    localparam int ADDR_W     = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int BIT_W      = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              reload_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic [TIM_W-1:0]  timing_i,
    output logic              busy_o,
    output logic              fuse_rd_strobe_o,
    output logic              fuse_pg_strobe_o,
    output logic [ADDR_W-1:0] fuse_addr_o,
    output logic [BIT_W-1:0]  fuse_bit_o,
    output logic              shad_we_o,
    output logic [ADDR_W-1:0] shad_addr_o,
    output logic [WORD_W-1:0] shad_data_o
);
    logic              tmr_load, tmr_done;
    logic [CNT_W-1:0]  tmr_len;
    logic              cur_bit, last_bit;
    logic              sh_latch, sh_capture, sh_advance;
    logic              blow;
    logic [ADDR_W-1:0] arr_addr;
    logic [WORD_W-1:0] rd_word;
    logic [BIT_W-1:0]  bit_idx;

    fuse_seq_ctrl #(
        .N_WORDS   (N_WORDS),
        .SETTLE_CYC(SETTLE_CYC),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .reload_i  (reload_i),
        .addr_i    (addr_i),
        .timing_i  (timing_i),
        .tmr_done  (tmr_done),
        .tmr_load  (tmr_load),
        .tmr_len   (tmr_len),
        .cur_bit   (cur_bit),
        .last_bit  (last_bit),
        .sh_latch  (sh_latch),
        .sh_capture(sh_capture),
        .sh_advance(sh_advance),
        .blow      (blow),
        .arr_addr  (arr_addr),
        .busy      (busy_o),
        .rd_strobe (fuse_rd_strobe_o),
        .pg_strobe (fuse_pg_strobe_o),
        .shad_we   (shad_we_o)
    );

    fuse_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk (clk),
        .rst (rst),
        .load(tmr_load),
        .len (tmr_len),
        .done(tmr_done)
    );

    fuse_bit_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .latch    (sh_latch),
        .data_i   (data_i),
        .capture  (sh_capture),
        .fuse_word(rd_word),
        .advance  (sh_advance),
        .cur_bit  (cur_bit),
        .bit_idx  (bit_idx),
        .last_bit (last_bit)
    );

    fuse_cell_array #(
        .N_WORDS(N_WORDS),
        .WORD_W (WORD_W)
    ) u_array (
        .clk      (clk),
        .rst      (rst),
        .rd_addr  (arr_addr),
        .rd_word  (rd_word),
        .blow     (blow),
        .blow_addr(arr_addr),
        .blow_bit (bit_idx)
    );

    assign fuse_addr_o = arr_addr;
    assign fuse_bit_o  = bit_idx;
    assign shad_addr_o = arr_addr;
    assign shad_data_o = rd_word;

endmodule

// File: tb/fuse_burn_seq_bench.sv
module fuse_burn_seq_bench;
    localparam int NW     = 4;
    localparam int WW     = 32;
    localparam int SETTLE = 5;
    localparam int AW     = 2;
    localparam int BW     = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          reload_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [WW-1:0] data_i = '0;
    logic [21:0]   timing_i = '0;
    logic          busy_o, fuse_rd_strobe_o, fuse_pg_strobe_o, shad_we_o;
    logic [AW-1:0] fuse_addr_o, shad_addr_o;
    logic [BW-1:0] fuse_bit_o;
    logic [WW-1:0] shad_data_o;

    fuse_burn_seq #(.N_WORDS(NW), .WORD_W(WW), .SETTLE_CYC(SETTLE), .CNT_W(16)) u_fuse_burn_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .reload_i(reload_i),
        .addr_i(addr_i), .data_i(data_i), .timing_i(timing_i),
        .busy_o(busy_o), .fuse_rd_strobe_o(fuse_rd_strobe_o),
        .fuse_pg_strobe_o(fuse_pg_strobe_o), .fuse_addr_o(fuse_addr_o),
        .fuse_bit_o(fuse_bit_o), .shad_we_o(shad_we_o),
        .shad_addr_o(shad_addr_o), .shad_data_o(shad_data_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    logic [WW-1:0] exp_fuse [NW];
    logic [WW-1:0] shad_mem [NW];

    // monitor state, sampled at the rising edge (pre-update values)
    int pulses, pg_cyc, rd_cyc, run_len, exp_p, len_err, order_err, last_bit, shad_cnt, addr_err;
    logic [AW-1:0] exp_addr;
    logic [WW-1:0] mask_seen;
    logic prev_pg = 1'b0;

    task automatic clear_mon();
        pulses = 0; pg_cyc = 0; rd_cyc = 0; run_len = 0; len_err = 0;
        order_err = 0; last_bit = -1; shad_cnt = 0; mask_seen = '0; addr_err = 0;
    endtask

    always @(posedge clk) begin
        if (!rst) begin
            if (fuse_rd_strobe_o) rd_cyc++;
            if (fuse_pg_strobe_o) begin
                pg_cyc++;
                run_len++;
                if (!prev_pg) begin
                    pulses++;
                    if (int'(fuse_bit_o) <= last_bit) order_err++;
                    if (rd_cyc == 0) order_err++;
                    last_bit = int'(fuse_bit_o);
                    mask_seen[fuse_bit_o] = 1'b1;
                    if (fuse_addr_o != exp_addr) addr_err++;
                end
            end else if (prev_pg) begin
                if (run_len != exp_p) len_err++;
                run_len = 0;
            end
            prev_pg = fuse_pg_strobe_o;
            if (shad_we_o) begin
                if (int'(shad_addr_o) != shad_cnt) addr_err++;
                shad_mem[shad_addr_o] = shad_data_o;
                shad_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int smax1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [21:0] pack_t(input int p, input int r, input int rd);
        return {6'(rd), 4'(r), 12'(p)};
    endfunction

    // waits while busy, returns number of busy cycles
    task automatic wait_busy(output int n);
        n = 0;
        while (busy_o && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_program(input logic [AW-1:0] a, input logic [WW-1:0] d,
                              input int p, input int r, input int rd,
                              input bit also_reload, input bit intrude);
        int n, k, expb;
        logic [WW-1:0] m;
        clear_mon();
        m = d & ~exp_fuse[a];
        k = $countones(m);
        exp_p = smax1(p);
        exp_addr = a;
        @(negedge clk);
        addr_i = a; data_i = d; timing_i = pack_t(p, r, rd);
        start_i = 1'b1; reload_i = also_reload;
        @(negedge clk);
        start_i = 1'b0; reload_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
        n = 1;
        @(negedge clk);
        if (intrude) begin
            addr_i = a + AW'(1); data_i = '1; start_i = 1'b1; reload_i = 1'b1;
            n++;
            @(negedge clk);
            start_i = 1'b0; reload_i = 1'b0;
        end
        begin
            int rest;
            wait_busy(rest);
            n = n + rest;
        end
        expb = (r + 1) + smax1(rd) + 32 + k * (2 * (r + 1) + smax1(p)) + SETTLE;
        chk(n == expb, "R6 R7 busy length", n, expb);
        chk(pulses == k, "R3 strobe count", pulses, k);
        chk(mask_seen == m, "R3 masked bits", mask_seen, m);
        chk(len_err == 0, "R5 strobe length", len_err, 0);
        chk(order_err == 0, "R2 R4 read first and ascending", order_err, 0);
        chk(addr_err == 0, "R4 strobe address", addr_err, 0);
        chk(pg_cyc == k * smax1(p), "R5 strobe cycles", pg_cyc, k * smax1(p));
        chk(rd_cyc == smax1(rd), "R2 R5 single read strobe", rd_cyc, smax1(rd));
        chk(shad_cnt == 0, "R10 no reload during program", shad_cnt, 0);
        exp_fuse[a] = exp_fuse[a] | d;
    endtask

    task automatic do_reload(input int r, input int rd);
        int n, expb;
        clear_mon();
        @(negedge clk);
        timing_i = pack_t(0, r, rd);
        reload_i = 1'b1;
        @(negedge clk);
        reload_i = 1'b0;
        wait_busy(n);
        expb = NW * (r + smax1(rd) + 2);
        chk(n == expb, "R9 reload busy length", n, expb);
        chk(shad_cnt == NW, "R9 shadow writes", shad_cnt, NW);
        chk(addr_err == 0, "R9 ascending shadow index", addr_err, 0);
        chk(rd_cyc == NW * smax1(rd), "R9 read strobes", rd_cyc, NW * smax1(rd));
        chk(pulses == 0, "R9 no program strobe", pulses, 0);
        for (int w = 0; w < NW; w++)
            chk(shad_mem[w] == exp_fuse[w], "R8 shadow word", shad_mem[w], exp_fuse[w]);
    endtask

    task automatic test_reset();
        chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
        chk(fuse_rd_strobe_o == 1'b0, "R1 read strobe", fuse_rd_strobe_o, 0);
        chk(fuse_pg_strobe_o == 1'b0, "R1 program strobe", fuse_pg_strobe_o, 0);
        chk(shad_we_o == 1'b0, "R1 shadow write", shad_we_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int w = 0; w < NW; w++) begin
            exp_fuse[w] = '0;
            shad_mem[w] = 'x;
        end
        clear_mon();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        do_program(2'd1, 32'h0000_00A5, 3, 1, 2, 1'b0, 1'b0);  // R3 R4 base
        do_program(2'd1, 32'h0000_00FF, 3, 1, 2, 1'b0, 1'b0);  // R3 masking
        do_program(2'd3, 32'h8000_0001, 0, 0, 0, 1'b0, 1'b0);  // R5 zero fields
        do_program(2'd0, 32'hFFFF_FFFF, 2, 2, 5, 1'b0, 1'b0);  // R4 full word
        do_program(2'd2, 32'h0000_0000, 7, 3, 1, 1'b0, 1'b0);  // R3 no strobes
        do_program(2'd2, 32'h0F00_0010, 4, 1, 3, 1'b1, 1'b0);  // R10 both requests
        do_program(2'd2, 32'h0000_0300, 2, 1, 1, 1'b0, 1'b1);  // R10 intrusion
        do_reload(1, 2);                                        // R8 R9
        do_reload(0, 0);                                        // R9 minimum
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule